// File: doc/BRIEF.md
# Ping-Pong Audio Capture DMA Controller

This block takes a stream of 32-bit audio samples and writes them to local memory as a bus master. Software hands it two empty buffers of the same size. The block fills the first buffer and then moves on to the second. Each time a buffer fills, the block raises that buffer's full flag and carries on in the other buffer with no gap in the stream. Software drains a full buffer and re-arms it with a write-one acknowledge. If it is too late, incoming samples are thrown away and a sticky overrun flag is raised.

Samples first collect in a staging store of sixteen words. The store is sent to memory as one burst, using a valid/ready handshake, when it holds sixteen words or when the active buffer reaches its end. If a sample arrives while the previous burst is still waiting and is not being taken in that same cycle, the sample is dropped and a bandwidth-error flag is raised. A single interrupt line combines the four flags, each gated by its own enable bit.

The register port has one write channel and one combinational read channel. Registers are selected by a 3-bit index: control is 0, base of buffer A is 1, base of buffer B is 2, shared size is 3 and status is 4.

Top module: `pingpong_capture_dma`

## Requirements
- R1: Writing 0x80000000 to the control register (index 0) resets all control and status state in the next cycle. Control bit 31 always reads back as 0.
- R2: After either kind of reset the following hold: capture is off, buffer A is active, all four flags are 0, all enable bits are 0, irq is 0 and mem_valid is 0.
- R3: Consecutive accepted samples are written to base + 4·k, where k counts the samples accepted into the current buffer. A buffer is full when the byte offset after a sample reaches the size value (index 3).
- R4: With capture on (control bit 0), samples fill buffer A first. The sample that fills a buffer sets that buffer's full flag and moves capture to the other buffer, so the next sample goes to the other buffer's base and none is lost.
- R5: irq is 1 exactly when some flag is set and its enable bit is 1. The enable bits are control bits 1 (A full), 2 (B full), 3 (bandwidth error) and 4 (overrun), and they read back in place.
- R6: Writing 1 to control bit 8 clears the full flag of buffer A, and writing 1 to bit 9 clears the flag of buffer B. The buffer is then refilled from offset 0. Both bits read back as 0.
- R7: A sample that arrives while the active buffer is still full is discarded and sets the overrun flag. The flag stays set until control bit 11 is written with 1.
- R8: A sample that arrives while a burst is pending and mem_ready is low is discarded and sets the bandwidth-error flag. Writing 1 to control bit 10 clears that flag.
- R9: The status register (index 4) has these fields: bit 0 is 1 when buffer A takes the next sample, bit 1 is A full, bit 2 is B full, bit 3 is bandwidth error and bit 4 is overrun.
- R10: A burst is issued when sixteen words are staged or when the active buffer ends. mem_len gives the word count, word i is in mem_data[32i+31:32i], and the address, length and data are held until mem_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Register index for the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_idx | input | 3 | Register index for the read |
| reg_rd_data | output | 32 | Read data (combinational) |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 32 | Audio sample |
| mem_valid | output | 1 | Burst request pending |
| mem_ready | input | 1 | Memory takes the burst |
| mem_addr | output | 32 | Byte address of the burst's first word |
| mem_len | output | 5 | Words in the burst (1 to 16) |
| mem_data | output | 512 | Burst payload |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench fills both buffers back to back and checks that the first word in buffer B comes right after the last word in buffer A. A design that lost a sample at the switch, or reused buffer A, would show the wrong first word or the wrong address. It then lets both buffers stay full so that overrun occurs, and checks that the flag survives an acknowledge of a buffer and that the refilled buffer restarts at its base. A buffer that kept its old offset would write past its end. The bench also stalls the memory to force a bandwidth error with the interrupt disabled and then enabled, and it runs a buffer whose last sample also completes a sixteen-word burst. That case exposes a design that issues two bursts, or none, when the two flush causes coincide.

// File: rtl/pp_cap_pkg.sv
package pp_cap_pkg;
  localparam int unsigned REG_IDX_W = 3;
  localparam int unsigned REG_W     = 32;

  localparam logic [REG_IDX_W-1:0] IDX_CTRL   = 3'd0;
  localparam logic [REG_IDX_W-1:0] IDX_BASE_A = 3'd1;
  localparam logic [REG_IDX_W-1:0] IDX_BASE_B = 3'd2;
  localparam logic [REG_IDX_W-1:0] IDX_SIZE   = 3'd3;
  localparam logic [REG_IDX_W-1:0] IDX_STAT   = 3'd4;

  localparam int unsigned CB_RUN    = 0;
  localparam int unsigned CB_IEN    = 1;   // four enables from here
  localparam int unsigned CB_ACK    = 8;   // four acknowledges from here
  localparam int unsigned CB_SRST   = 31;
  localparam int unsigned NUM_FLAGS = 4;

  // flag order shared by enables, acknowledges and status (bit 1 upward)
  localparam int unsigned FL_FULL_A = 0;
  localparam int unsigned FL_FULL_B = 1;
  localparam int unsigned FL_BW     = 2;
  localparam int unsigned FL_OVR    = 3;
endpackage

// File: rtl/pp_cap_regs.sv
module pp_cap_regs
  import pp_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [REG_IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0]     rd_data,
  input  logic                 full_a,
  input  logic                 full_b,
  input  logic                 act_a,
  input  logic                 set_bw,
  input  logic                 set_ovr,
  output logic                 cap_en,
  output logic                 ack_a,
  output logic                 ack_b,
  output logic                 ack_ovr,
  output logic                 soft_rst,
  output logic [ADDR_W-1:0]    base_a,
  output logic [ADDR_W-1:0]    base_b,
  output logic [SIZE_W-1:0]    size,
  output logic [NUM_FLAGS-1:0] ien,
  output logic                 bw_err,
  output logic                 ovr,
  output logic                 irq
);
  logic                 ctrl_wr, ctrl_norm, ack_bw;
  logic                 cap_en_d, bw_d, ovr_d;
  logic [NUM_FLAGS-1:0] ien_d, flags;
  logic                 base_a_we, base_b_we, size_we;

  assign ctrl_wr   = wr_en && (wr_idx == IDX_CTRL);
  assign soft_rst  = ctrl_wr && wr_data[CB_SRST];
  assign ctrl_norm = ctrl_wr && !wr_data[CB_SRST];
  assign ack_a     = ctrl_norm && wr_data[CB_ACK + FL_FULL_A];
  assign ack_b     = ctrl_norm && wr_data[CB_ACK + FL_FULL_B];
  assign ack_bw    = ctrl_norm && wr_data[CB_ACK + FL_BW];
  assign ack_ovr   = ctrl_norm && wr_data[CB_ACK + FL_OVR];
  assign base_a_we = wr_en && (wr_idx == IDX_BASE_A);
  assign base_b_we = wr_en && (wr_idx == IDX_BASE_B);
  assign size_we   = wr_en && (wr_idx == IDX_SIZE);

  always_comb begin
    cap_en_d = cap_en;
    ien_d    = ien;
    bw_d     = set_bw  || (bw_err && !ack_bw);
    ovr_d    = set_ovr || (ovr && !ack_ovr);
    if (ctrl_norm) begin
      cap_en_d = wr_data[CB_RUN];
      ien_d    = wr_data[CB_IEN +: NUM_FLAGS];
    end
    if (soft_rst) begin
      cap_en_d = 1'b0;
      ien_d    = '0;
      bw_d     = 1'b0;
      ovr_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en <= 1'b0;
      ien    <= '0;
      bw_err <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      cap_en <= cap_en_d;
      ien    <= ien_d;
      bw_err <= bw_d;
      ovr    <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a <= '0;
      base_b <= '0;
      size   <= '0;
    end else begin
      if (base_a_we) base_a <= wr_data[ADDR_W-1:0];
      if (base_b_we) base_b <= wr_data[ADDR_W-1:0];
      if (size_we)   size   <= wr_data[SIZE_W-1:0];
    end
  end

  always_comb begin
    flags            = '0;
    flags[FL_FULL_A] = full_a;
    flags[FL_FULL_B] = full_b;
    flags[FL_BW]     = bw_err;
    flags[FL_OVR]    = ovr;
  end

  assign irq = |(flags & ien);

  always_comb begin
    rd_data = '0;
    unique case (rd_idx)
      IDX_CTRL: begin
        rd_data[CB_RUN]              = cap_en;
        rd_data[CB_IEN +: NUM_FLAGS] = ien;
      end
      IDX_BASE_A: rd_data[ADDR_W-1:0] = base_a;
      IDX_BASE_B: rd_data[ADDR_W-1:0] = base_b;
      IDX_SIZE:   rd_data[SIZE_W-1:0] = size;
      IDX_STAT: begin
        rd_data[0]             = act_a;
        rd_data[1 +: NUM_FLAGS] = flags;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pp_cap_seq.sv
module pp_cap_seq #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned BYTES_PER_SMP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cap_en,
  input  logic              smp_valid,
  input  logic              can_stage,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  input  logic [SIZE_W-1:0] size,
  input  logic              ack_a,
  input  logic              ack_b,
  output logic              stage_we,
  output logic              buf_end,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              set_bw,
  output logic              set_ovr,
  output logic              full_a,
  output logic              full_b,
  output logic              act_a
);
  localparam int unsigned OFF_W = SIZE_W + 1;

  logic [OFF_W-1:0] offset, off_next, off_d;
  logic             take, act_full, act_d, fa_d, fb_d;

  assign take     = cap_en && smp_valid;
  assign act_full = act_a ? full_a : full_b;
  assign set_ovr  = take && act_full;
  assign set_bw   = take && !act_full && !can_stage;
  assign stage_we = take && !act_full && can_stage;
  assign off_next = offset + OFF_W'(BYTES_PER_SMP);
  assign buf_end  = stage_we && (off_next >= {1'b0, size});
  assign wr_addr  = (act_a ? base_a : base_b) + ADDR_W'(offset);

  always_comb begin
    off_d = offset;
    if (buf_end)       off_d = '0;
    else if (stage_we) off_d = off_next;
    act_d = buf_end ? !act_a : act_a;
    fa_d  = (buf_end && act_a)  || (full_a && !ack_a);
    fb_d  = (buf_end && !act_a) || (full_b && !ack_b);
    if (soft_rst) begin
      off_d = '0;
      act_d = 1'b1;
      fa_d  = 1'b0;
      fb_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset <= '0;
      act_a  <= 1'b1;
      full_a <= 1'b0;
      full_b <= 1'b0;
    end else begin
      offset <= off_d;
      act_a  <= act_d;
      full_a <= fa_d;
      full_b <= fb_d;
    end
  end
endmodule

// File: rtl/pp_cap_stage.sv
module pp_cap_stage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    soft_rst,
  input  logic                    stage_we,
  input  logic                    buf_end,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    mem_ready,
  output logic                    can_stage,
  output logic                    mem_valid,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [CNT_W-1:0]        mem_len,
  output logic [DATA_W*DEPTH-1:0] mem_data
);
  logic [CNT_W-1:0] cnt, cnt_inc, cnt_d, len_d;
  logic             pending, pend_d, flush, first_we;

  assign can_stage = !pending || mem_ready;
  assign cnt_inc   = cnt + CNT_W'(1);
  assign flush     = stage_we && (buf_end || (cnt_inc == CNT_W'(DEPTH)));
  assign first_we  = stage_we && (cnt == '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              word_we;
    assign word_we = stage_we && (cnt == CNT_W'(g));
    always_ff @(posedge clk) begin
      if (word_we) word_q <= wdata;
    end
    assign mem_data[g*DATA_W +: DATA_W] = word_q;
  end

  always_comb begin
    cnt_d  = cnt;
    len_d  = mem_len;
    pend_d = pending && !mem_ready;
    if (stage_we) cnt_d = flush ? '0 : cnt_inc;
    if (flush) begin
      len_d  = cnt_inc;
      pend_d = 1'b1;
    end
    if (soft_rst) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
      mem_len <= '0;
    end else begin
      cnt     <= cnt_d;
      pending <= pend_d;
      mem_len <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mem_addr <= '0;
    else if (first_we) mem_addr <= wr_addr;
  end

  assign mem_valid = pending;
endmodule

// File: rtl/pingpong_capture_dma.sv
module pingpong_capture_dma
  import pp_cap_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SIZE_W      = 16,
  parameter int unsigned STAGE_WORDS = 16,
  localparam int unsigned LEN_W      = $clog2(STAGE_WORDS + 1),
  localparam int unsigned BURST_W    = DATA_W * STAGE_WORDS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [REG_IDX_W-1:0] reg_wr_idx,
  input  logic [REG_W-1:0]     reg_wr_data,
  input  logic [REG_IDX_W-1:0] reg_rd_idx,
  output logic [REG_W-1:0]     reg_rd_data,
  input  logic                 smp_valid,
  input  logic [DATA_W-1:0]    smp_data,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [LEN_W-1:0]     mem_len,
  output logic [BURST_W-1:0]   mem_data,
  output logic                 irq
);
  localparam int unsigned BYTES_PER_SMP = DATA_W / 8;

  logic                 soft_rst, cap_en, ack_a, ack_b, ack_ovr;
  logic                 full_a, full_b, act_a, bw_err, ovr;
  logic                 set_bw, set_ovr, stage_we, buf_end, can_stage;
  logic [ADDR_W-1:0]    base_a, base_b, wr_addr;
  logic [SIZE_W-1:0]    size;
  logic [NUM_FLAGS-1:0] ien;

  pp_cap_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_idx(reg_wr_idx), .wr_data(reg_wr_data),
    .rd_idx(reg_rd_idx), .rd_data(reg_rd_data),
    .full_a(full_a), .full_b(full_b), .act_a(act_a),
    .set_bw(set_bw), .set_ovr(set_ovr),
    .cap_en(cap_en), .ack_a(ack_a), .ack_b(ack_b), .ack_ovr(ack_ovr),
    .soft_rst(soft_rst), .base_a(base_a), .base_b(base_b), .size(size),
    .ien(ien), .bw_err(bw_err), .ovr(ovr), .irq(irq)
  );

  pp_cap_seq #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BYTES_PER_SMP(BYTES_PER_SMP)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cap_en(cap_en), .smp_valid(smp_valid), .can_stage(can_stage),
    .base_a(base_a), .base_b(base_b), .size(size),
    .ack_a(ack_a), .ack_b(ack_b),
    .stage_we(stage_we), .buf_end(buf_end), .wr_addr(wr_addr),
    .set_bw(set_bw), .set_ovr(set_ovr),
    .full_a(full_a), .full_b(full_b), .act_a(act_a)
  );

  pp_cap_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(STAGE_WORDS)) u_stage (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .stage_we(stage_we), .buf_end(buf_end), .wr_addr(wr_addr), .wdata(smp_data),
    .mem_ready(mem_ready), .can_stage(can_stage),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_len(mem_len), .mem_data(mem_data)
  );
endmodule

// File: rtl/pp_cap_chk.sv
module pp_cap_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 5,
  parameter int unsigned DEPTH  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LEN_W-1:0]  mem_len,
  input logic              irq,
  input logic [3:0]        ien,
  input logic              full_a,
  input logic              full_b,
  input logic              act_a,
  input logic              bw_err,
  input logic              ovr,
  input logic              ack_ovr
);
  assert_srst_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> act_a && !full_a && !full_b && !bw_err && !ovr && !mem_valid && (ien == '0));

  assert_irq_ovr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && ien[3]) |-> irq);

  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ack_ovr && !soft_rst) |=> ovr);

  assert_switch_on_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_a) |-> !act_a);

  assert_burst_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !soft_rst) |=> mem_valid && $stable(mem_addr) && $stable(mem_len));

  assert_burst_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_len != '0) && (mem_len <= LEN_W'(DEPTH)));
endmodule

bind pingpong_capture_dma pp_cap_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(STAGE_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_len(mem_len),
  .irq(irq), .ien(ien), .full_a(full_a), .full_b(full_b), .act_a(act_a),
  .bw_err(bw_err), .ovr(ovr), .ack_ovr(ack_ovr)
);

// File: tb/pingpong_capture_dma_bench.sv
module pingpong_capture_dma_bench;
  logic         clk, rst_n;
  logic         reg_wr_en;
  logic [2:0]   reg_wr_idx, reg_rd_idx;
  logic [31:0]  reg_wr_data, reg_rd_data;
  logic         smp_valid;
  logic [31:0]  smp_data;
  logic         mem_valid, mem_ready, irq;
  logic [31:0]  mem_addr;
  logic [4:0]   mem_len;
  logic [511:0] mem_data;

  int n_chk = 0, n_fail = 0, nb = 0;
  logic [31:0] b_addr [16];
  logic [4:0]  b_len  [16];
  logic [31:0] b_first[16];
  logic [31:0] b_last [16];

  pingpong_capture_dma u_pingpong_capture_dma (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
    .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_data(mem_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready && nb < 16) begin
      b_addr[nb]  <= mem_addr;
      b_len[nb]   <= mem_len;
      b_first[nb] <= mem_data[31:0];
      b_last[nb]  <= mem_data[32*(mem_len-1) +: 32];
      nb          <= nb + 1;
    end
  end

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] idx, output logic [31:0] d);
    reg_rd_idx = idx;
    #1 d = reg_rd_data;
  endtask

  task automatic send(input int n, input logic [31:0] start);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b1; smp_data = start + 32'(i);
    end
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(3'd4, v);  check("R2/R9 status after reset", v, 32'h1);
    reg_rd(3'd0, v);  check("R2 ctrl after reset", v, 32'h0);
    check("R2 irq after reset", {31'b0, irq}, 32'h0);
    check("R2 mem_valid after reset", {31'b0, mem_valid}, 32'h0);
  endtask

  task automatic t_fill_a();
    logic [31:0] v;
    reg_wr(3'd1, 32'h1000);
    reg_wr(3'd2, 32'h2000);
    reg_wr(3'd3, 32'h20);
    reg_wr(3'd0, 32'h3);
    reg_rd(3'd0, v);  check("R5 enables read back", v, 32'h3);
    send(8, 32'hA000_0000);
    check("R10 one burst at buffer end", nb, 1);
    check("R3 burst address base A", b_addr[0], 32'h1000);
    check("R10 burst length", {27'b0, b_len[0]}, 32'd8);
    check("R3 first word", b_first[0], 32'hA000_0000);
    check("R3 last word", b_last[0], 32'hA000_0007);
    reg_rd(3'd4, v);  check("R4/R9 A full, B active", v, 32'h2);
    check("R5 irq on A full", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_fill_b();
    logic [31:0] v;
    send(8, 32'hB000_0000);
    check("R4 burst count after B", nb, 2);
    check("R4 burst address base B", b_addr[1], 32'h2000);
    check("R4 no sample lost at switch", b_first[1], 32'hB000_0000);
    reg_rd(3'd4, v);  check("R4/R9 both full, A active", v, 32'h7);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    send(2, 32'hC000_0000);
    check("R7 no burst during overrun", nb, 2);
    reg_rd(3'd4, v);  check("R7 overrun flag", v, 32'h17);
    reg_wr(3'd0, 32'h103);
    reg_rd(3'd4, v);  check("R6 ack A clears full A", v, 32'h15);
    reg_rd(3'd0, v);  check("R6 ack bit reads 0", v, 32'h3);
    send(8, 32'hD000_0000);
    check("R6 burst after re-arm", nb, 3);
    check("R6 restart at base A", b_addr[2], 32'h1000);
    check("R6 first word after re-arm", b_first[2], 32'hD000_0000);
    reg_rd(3'd4, v);  check("R7 overrun still sticky", v, 32'h16);
    reg_wr(3'd0, 32'h803);
    reg_rd(3'd4, v);  check("R7 ack clears overrun", v, 32'h6);
  endtask

  task automatic t_bandwidth();
    logic [31:0] v;
    reg_wr(3'd0, 32'h8000_0000);
    reg_rd(3'd4, v);  check("R1 status after soft reset", v, 32'h1);
    reg_rd(3'd0, v);  check("R1 ctrl after soft reset", v, 32'h0);
    check("R1 irq after soft reset", {31'b0, irq}, 32'h0);
    mem_ready = 1'b0;
    reg_wr(3'd3, 32'h80);
    reg_wr(3'd0, 32'h1);
    send(16, 32'hE000_0000);
    check("R10 burst waits for ready", {31'b0, mem_valid}, 32'h1);
    check("R10 pending address", mem_addr, 32'h1000);
    send(1, 32'hEEEE_EEEE);
    reg_rd(3'd4, v);  check("R8 bandwidth error flag", v, 32'h9);
    check("R5 irq masked", {31'b0, irq}, 32'h0);
    reg_wr(3'd0, 32'h9);
    check("R5 irq after enabling bw", {31'b0, irq}, 32'h1);
    mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 stalled burst delivered", nb, 4);
    check("R10 full burst length", {27'b0, b_len[3]}, 32'd16);
    check("R8 dropped sample absent", b_last[3], 32'hE000_000F);
    reg_wr(3'd0, 32'h409);
    reg_rd(3'd4, v);  check("R8 ack clears bw", v, 32'h1);
    check("R5 irq drops after ack", {31'b0, irq}, 32'h0);
    send(16, 32'hF000_0000);
    check("R3 second burst issued", nb, 5);
    check("R3 offset continues", b_addr[4], 32'h1040);
    check("R3 burst starts after dropped one", b_first[4], 32'hF000_0000);
    reg_rd(3'd4, v);  check("R3 buffer end with full burst", v, 32'h2);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_idx = '0; reg_wr_data = '0;
    reg_rd_idx = '0; smp_valid = 1'b0; smp_data = '0; mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_a();
    t_fill_b();
    t_overrun();
    t_bandwidth();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule